// File: doc/BRIEF.md
# Modem Control and Status Unit

This block sits in a UART-style serial controller next to the serial datapath and owns the modem handshake lines. Software writes a small control register whose low four bits drive four active-low handshake outputs: terminal ready, request to send, and two general-purpose outputs. A loop-mode input forces all four outputs to their idle high level. In loop mode the control bits are also routed back into the status view, so the handshake path can be tested without any external wiring.

The four active-low handshake inputs are clear to send, data set ready, ring indicate and carrier detect. Each passes through a synchronizer. The status register reports their present levels in its upper nibble. Its lower nibble holds sticky change flags. The ring-indicate flag is set only when the ring pin returns high, that is, when the ring pulse ends. Reading the status register returns the flags and clears them in the same cycle, without losing a change that arrives during that read. An interrupt request is raised while any flag is set and the modem interrupt enable input is high.

Top module: `modem_ctl_unit`

## Requirements
- R1: After a synchronous reset with all input pins high: all four outputs are high, `irq` is 0, `rdata` is 0, and a control read and a status read both return 0x00.
- R2: A write with `reg_sel`=0 stores `wdata[3:0]` in the control register. A control read returns those bits in `rdata[3:0]`, with all higher bits 0.
- R3: Control bit 0 drives `dtr_n`, bit 1 `rts_n`, bit 2 `out1_n` and bit 3 `out2_n`. A set bit drives its pin low from the clock edge that takes the write, and a cleared bit drives it high.
- R4: While `loop_mode` is 1, all four outputs are high from the next clock edge on, whatever the control bits hold.
- R5: Status bit 4 reports clear-to-send, bit 5 data-set-ready, bit 6 ring and bit 7 carrier detect. Each bit is the inverse of its pin, taken after `SYNC_STAGES` synchronizer flops and one level register.
- R6: Status bit 0 (clear-to-send), bit 1 (data-set-ready) and bit 3 (carrier detect) are set on either edge of their reported level. They stay set until a status read.
- R7: Status bit 2 is set only when `ri_n` goes from low to high. A high-to-low transition of `ri_n` leaves it clear.
- R8: A read with `reg_sel`=1 returns the status byte registered in `rdata` and clears bits 0 to 3 at the same edge. A change that the level register takes at that edge is still recorded. Control reads clear nothing.
- R9: In loop mode the levels come from the control bits: request-to-send feeds clear-to-send, terminal ready feeds data-set-ready, output 1 feeds ring, and output 2 feeds carrier detect. The input pins are ignored.
- R10: `irq` is registered and equals `msi_en` AND any change flag, as they stand after each edge. It falls at the edge of a clearing status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | 0 selects control register, 1 selects status register |
| wr_en | input | 1 | Write strobe (control register only) |
| rd_en | input | 1 | Read strobe |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| msi_en | input | 1 | Modem interrupt enable |
| loop_mode | input | 1 | Loop-mode select |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring-indicate pin, active low |
| dcd_n | input | 1 | Carrier-detect pin, active low |
| dtr_n | output | 1 | Terminal-ready output, active low |
| rts_n | output | 1 | Request-to-send output, active low |
| out1_n | output | 1 | General output 1, active low |
| out2_n | output | 1 | General output 2, active low |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The bench builds the unit with `SYNC_STAGES`=2 and `DATA_W`=8. With these values, a pin change shows in the flags three edges after it is driven. This fixed latency lets the bench place a status read on exactly the edge where a new change lands, so the capture-during-clear path is exercised. A full byte bus also exposes the zero upper bits of control reads. Loop entry, loop exit and the ring trailing edge are all reached through the control register alone.

// File: rtl/modem_pkg.sv
package modem_pkg;
  // Index of each modem input inside level and change vectors
  localparam int IDX_CTS = 0;
  localparam int IDX_DSR = 1;
  localparam int IDX_RI  = 2;
  localparam int IDX_DCD = 3;
  localparam int NUM_IN  = 4;

  // Control register bit positions
  localparam int CTL_DTR  = 0;
  localparam int CTL_RTS  = 1;
  localparam int CTL_OUT1 = 2;
  localparam int CTL_OUT2 = 3;
  localparam int CTL_W    = 4;

  // Register select encoding
  localparam logic SEL_CTRL = 1'b0;
  localparam logic SEL_STAT = 1'b1;

  typedef logic [NUM_IN-1:0] mvec_t;
  typedef logic [CTL_W-1:0]  cvec_t;
endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] chain [STAGES];

  // Pins idle high, so every stage resets to ones
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '1;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[LAST];
endmodule

// File: rtl/modem_ctl_reg.sv
module modem_ctl_reg
  import modem_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  wr_ctl,
  input  cvec_t wdata,
  input  logic  loop_mode,
  output cvec_t ctrl_q,
  output cvec_t pins_n
);
  cvec_t ctrl_d;
  cvec_t pins_d;

  assign ctrl_d = wr_ctl ? wdata : ctrl_q;

  genvar g;
  generate
    for (g = 0; g < CTL_W; g++) begin : g_pin
      // Active-low drive, held idle in loop mode
      assign pins_d[g] = loop_mode | ~ctrl_d[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      pins_n <= '1;
    end else begin
      ctrl_q <= ctrl_d;
      pins_n <= pins_d;
    end
  end

  assert_loop_idle_R4: assert property (@(posedge clk) disable iff (rst)
    loop_mode |=> (&pins_n));

  assert_pins_follow_ctrl_R3: assert property (@(posedge clk) disable iff (rst)
    !loop_mode |=> (pins_n == ~ctrl_q));
endmodule

// File: rtl/modem_status.sv
module modem_status
  import modem_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mvec_t pin_lvl,
  input  logic  loop_mode,
  input  cvec_t ctrl_q,
  input  logic  stat_rd,
  input  logic  msi_en,
  output mvec_t lvl_q,
  output mvec_t delta_q,
  output logic  irq
);
  mvec_t loop_lvl;
  mvec_t lvl_src;
  mvec_t change;
  mvec_t delta_d;

  // Loopback routing of control bits into the status view
  assign loop_lvl[IDX_CTS] = ctrl_q[CTL_RTS];
  assign loop_lvl[IDX_DSR] = ctrl_q[CTL_DTR];
  assign loop_lvl[IDX_RI]  = ctrl_q[CTL_OUT1];
  assign loop_lvl[IDX_DCD] = ctrl_q[CTL_OUT2];

  assign lvl_src = loop_mode ? loop_lvl : pin_lvl;

  genvar g;
  generate
    for (g = 0; g < NUM_IN; g++) begin : g_edge
      if (g == IDX_RI) begin : g_trail
        // Ring flag only when the active level ends (pin returns high)
        assign change[g] = lvl_q[g] & ~lvl_src[g];
      end else begin : g_any
        assign change[g] = lvl_q[g] ^ lvl_src[g];
      end
    end
  endgenerate

  assign delta_d = (stat_rd ? '0 : delta_q) | change;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q   <= '0;
      delta_q <= '0;
      irq     <= 1'b0;
    end else begin
      lvl_q   <= lvl_src;
      delta_q <= delta_d;
      irq     <= msi_en & (|delta_d);
    end
  end

  assert_delta_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    !stat_rd |=> ((delta_q & $past(delta_q)) == $past(delta_q)));

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && (change == '0)) |=> (delta_q == '0));

  assert_ri_trailing_only_R7: assert property (@(posedge clk) disable iff (rst)
    (!delta_q[IDX_RI] && !(lvl_q[IDX_RI] && !lvl_src[IDX_RI])) |=> !delta_q[IDX_RI]);

  assert_irq_enabled_R10: assert property (@(posedge clk) disable iff (rst)
    msi_en |=> (irq == (|delta_q)));

  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (rst)
    !msi_en |=> !irq);
endmodule

// File: rtl/modem_ctl_unit.sv
module modem_ctl_unit
  import modem_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              msi_en,
  input  logic              loop_mode,
  input  logic              cts_n,
  input  logic              dsr_n,
  input  logic              ri_n,
  input  logic              dcd_n,
  output logic              dtr_n,
  output logic              rts_n,
  output logic              out1_n,
  output logic              out2_n,
  output logic              irq
);
  localparam int LVL_LSB = NUM_IN;
  localparam int LVL_MSB = 2 * NUM_IN - 1;

  mvec_t pins_raw;
  mvec_t pins_sync;
  mvec_t pin_lvl;
  mvec_t lvl_q;
  mvec_t delta_q;
  cvec_t ctrl_q;
  cvec_t pins_n;
  logic  wr_ctl;
  logic  stat_rd;
  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] ctrl_word;

  initial begin
    if (DATA_W < 2 * NUM_IN) $error("DATA_W too small for status byte");
  end

  assign wr_ctl  = wr_en & (reg_sel == SEL_CTRL);
  assign stat_rd = rd_en & (reg_sel == SEL_STAT);

  assign pins_raw[IDX_CTS] = cts_n;
  assign pins_raw[IDX_DSR] = dsr_n;
  assign pins_raw[IDX_RI]  = ri_n;
  assign pins_raw[IDX_DCD] = dcd_n;

  modem_sync #(.STAGES(SYNC_STAGES), .WIDTH(NUM_IN)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pins_raw),
    .dout (pins_sync)
  );

  assign pin_lvl = ~pins_sync;

  modem_ctl_reg u_ctl (
    .clk       (clk),
    .rst       (rst),
    .wr_ctl    (wr_ctl),
    .wdata     (wdata[CTL_W-1:0]),
    .loop_mode (loop_mode),
    .ctrl_q    (ctrl_q),
    .pins_n    (pins_n)
  );

  modem_status u_stat (
    .clk       (clk),
    .rst       (rst),
    .pin_lvl   (pin_lvl),
    .loop_mode (loop_mode),
    .ctrl_q    (ctrl_q),
    .stat_rd   (stat_rd),
    .msi_en    (msi_en),
    .lvl_q     (lvl_q),
    .delta_q   (delta_q),
    .irq       (irq)
  );

  assign dtr_n  = pins_n[CTL_DTR];
  assign rts_n  = pins_n[CTL_RTS];
  assign out1_n = pins_n[CTL_OUT1];
  assign out2_n = pins_n[CTL_OUT2];

  always_comb begin
    stat_word = '0;
    stat_word[LVL_MSB:LVL_LSB] = lvl_q;
    stat_word[NUM_IN-1:0]      = delta_q;
    ctrl_word = '0;
    ctrl_word[CTL_W-1:0]       = ctrl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= (reg_sel == SEL_STAT) ? stat_word : ctrl_word;
    end
  end

  assert_ctrl_read_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (reg_sel == SEL_CTRL)) |=> (rdata[DATA_W-1:CTL_W] == '0));
endmodule

// File: tb/tb_modem_ctl_unit.sv
module tb_modem_ctl_unit;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC_ST    = 2;
  localparam int DW         = 8;
  localparam int SETTLE     = SYNC_ST + 2;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst, reg_sel, wr_en, rd_en, msi_en, loop_mode;
  logic [DW-1:0] wdata, rdata;
  logic cts_n, dsr_n, ri_n, dcd_n;
  logic dtr_n, rts_n, out1_n, out2_n, irq;

  int checks = 0;
  int errors = 0;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       mon_pend = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modem_ctl_unit #(.SYNC_STAGES(SYNC_ST), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .msi_en(msi_en), .loop_mode(loop_mode),
    .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
    .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n), .irq(irq)
  );

  task automatic check_eq(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic check_outs(string tag, logic [3:0] exp_n);
    check_eq(tag, {4'b0, out2_n, out1_n, rts_n, dtr_n}, {4'b0, exp_n});
  endtask

  // Monitor: note a read strobe at the edge, compare at the following negedge
  always @(posedge clk) mon_pend <= rd_en & ~rst;

  always @(negedge clk) begin
    if (mon_pend) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: actual=0x%02h expected=none", rdata);
      end else begin
        check_eq(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  // Driver tasks: called at a negedge, return at a negedge
  task automatic do_read(logic sel, logic [7:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    reg_sel = sel; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_write(logic [7:0] d);
    reg_sel = 1'b0; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; reg_sel = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wdata = '0;
    msi_en = 1'b0; loop_mode = 1'b0;
    cts_n = 1'b1; dsr_n = 1'b1; ri_n = 1'b1; dcd_n = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check_outs("R1 outputs idle", 4'hF);
    check_eq("R1 irq low", {7'b0, irq}, 8'h00);
    check_eq("R1 rdata zero", rdata, 8'h00);
    do_read(1'b0, 8'h00, "R1 control read");
    do_read(1'b1, 8'h00, "R1 status read");

    // R2/R3 control register and output mapping
    do_write(8'hF5);
    check_outs("R3 dtr+out1 active", 4'b1010);
    do_read(1'b0, 8'h05, "R2 control readback upper zero");
    do_write(8'h0A);
    check_outs("R3 rts+out2 active", 4'b0101);

    // R5/R6 clear-to-send change; control read must not clear (R8)
    cts_n = 1'b0; settle();
    do_read(1'b0, 8'h0A, "R8 control read keeps flags");
    do_read(1'b1, 8'h11, "R5 R6 cts level and change");
    do_read(1'b1, 8'h10, "R8 flags cleared by status read");

    // R6 dsr pulse (sticky) and carrier detect
    dsr_n = 1'b0; dcd_n = 1'b0; settle();
    dsr_n = 1'b1; settle();
    do_read(1'b1, 8'h9A, "R6 dsr sticky and dcd change");

    // R7 ring: leading edge no flag, trailing edge flag
    ri_n = 1'b0; settle();
    do_read(1'b1, 8'hD0, "R7 ring falling pin no flag");
    ri_n = 1'b1; settle();
    do_read(1'b1, 8'h94, "R7 ring trailing edge flag");
    do_read(1'b1, 8'h90, "R8 ring flag cleared");

    // R10 interrupt request
    msi_en = 1'b1; @(negedge clk);
    check_eq("R10 irq idle with no flags", {7'b0, irq}, 8'h00);
    cts_n = 1'b1; settle();
    check_eq("R10 irq raised", {7'b0, irq}, 8'h01);
    do_read(1'b1, 8'h81, "R10 status at interrupt");
    check_eq("R10 irq dropped after read", {7'b0, irq}, 8'h00);
    msi_en = 1'b0; dcd_n = 1'b1; settle();
    check_eq("R10 irq masked", {7'b0, irq}, 8'h00);
    do_read(1'b1, 8'h08, "R10 masked change still flagged");

    // R8 change landing at the read edge is kept
    cts_n = 1'b0;
    repeat (SYNC_ST) @(negedge clk);
    do_read(1'b1, 8'h00, "R8 read at capture edge");
    do_read(1'b1, 8'h11, "R8 change captured during read");
    cts_n = 1'b1; settle();
    do_read(1'b1, 8'h01, "R6 cts release change");

    // R4/R9 loop mode
    do_write(8'h0F);
    check_outs("R3 all active", 4'h0);
    loop_mode = 1'b1; @(negedge clk);
    check_outs("R4 loop forces idle", 4'hF);
    settle();
    do_read(1'b1, 8'hFB, "R9 loop levels from control");
    cts_n = 1'b0; settle();
    do_read(1'b1, 8'hF0, "R9 pins ignored in loop");
    do_write(8'h0B);
    check_outs("R4 idle after write in loop", 4'hF);
    settle();
    do_read(1'b1, 8'hB4, "R9 R7 out1 clear gives ring trailing flag");
    loop_mode = 1'b0; settle();
    do_read(1'b1, 8'h1A, "R9 loop exit returns to pins");
    check_outs("R3 outputs after loop exit", 4'b0100);
    do_read(1'b0, 8'h0B, "R2 control kept through loop");

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule